// File: doc/BRIEF.md
# Bit-Clocked Half-Duplex Serial Transceiver

This block is the device-side physical layer of a two-wire debug link. The host supplies the bit clock on one wire and shares a single data wire for both directions. The block samples the host's link clock and data in its own system clock domain and finds each rising edge of the link clock. On each such edge it shifts in one bit of a host frame. A frame is a low start bit, eight data bits with the least significant bit first, an even parity bit and the stop bits. Each received byte is handed to the upper layer with a one-cycle valid strobe, together with parity and framing error flags.

When the upper layer has a reply, it hands the transceiver one byte with a start pulse. The block then drives the data wire for exactly one frame, from the start bit through the last stop bit. It changes each bit just after a rising link edge, so the bit is stable when the host samples it at the next rising edge. The pin itself is not part of the block: the output enable and the output value go to an external tri-state buffer, and the pin level comes back on the input.

The link is half-duplex. While a reply is pending or being sent, the receiver does not start new frames, so it never decodes the device's own transmission. A reply that is requested while a host frame is still arriving waits until that frame has ended.

Top module: `bitclk_serial_xcvr`

## Requirements
- R1: After reset, the output enable is low, the data output is high, the received-byte strobe is low and the transmit busy flag is low.
- R2: While the receiver is idle, a low data level at a rising link edge is a start bit. The next eight rising edges give data bits 0 to 7 in that order. The byte appears on the received-byte bus with a strobe one system cycle long, after the last stop bit has been sampled.
- R3: The bit that follows data bit 7 must equal the XOR of the eight data bits. If it does not, the parity error flag is high together with that byte's strobe, and low otherwise.
- R4: The stop positions follow the parity bit, two of them by default. A low level at any stop position sets the framing error flag together with that byte's strobe.
- R5: A transmitted frame is a 0 start bit, then data bits 0 to 7, then the even parity bit (the XOR of the data), then two stop bits at 1. Each bit is updated only after a rising link edge and is held until the next one.
- R6: The output enable is high from the transmitted start bit through the last stop bit. It is low at every other time, and the data output is high whenever the enable is low.
- R7: A transmit start pulse is accepted only while the busy flag is low. Once accepted, the busy flag stays high until the frame has ended. A pulse that arrives while busy is ignored, and its byte is never sent.
- R8: The receiver starts no frame while the transmitter is busy. A reply requested during a host frame does not drive the line until that frame has been delivered.
- R9: Reception and transmission are correct at every link clock period of at least several system clock cycles, including a slow rate and a fast rate.
- R10: A data line that stays high while the receiver is idle produces no received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_clk | input | 1 | Bit clock driven by the host |
| lnk_din | input | 1 | Level seen on the shared data pin |
| lnk_dout | output | 1 | Value the device drives onto the data pin |
| lnk_oe | output | 1 | Output enable for the data pin buffer |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_par_err | output | 1 | Parity mismatch for the strobed byte |
| rx_frm_err | output | 1 | A stop position was low for the strobed byte |
| tx_data | input | 8 | Reply byte |
| tx_start | input | 1 | Request to send tx_data |
| tx_busy | output | 1 | A reply is pending or being sent |

## Verification
The assertions check the following on every cycle:
- the line outputs change only right after a detected rising link edge;
- the line rests high whenever the output enable is low;
- each enabled period begins with a low start bit;
- the received-byte strobe is one cycle long and follows a link edge;
- no byte is strobed while the line is driven.

Only the bench scenarios can show the rest:
- the decoded data, parity and framing values;
- the exact bit sequence the host sees on the wire;
- that a request made while busy is dropped;
- that a reply requested during a host frame is deferred;
- that both behave the same at a slow and a fast link clock.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [1:0] {TX_IDLE, TX_PEND, TX_SEND} tx_state_e;
   typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;

   function automatic logic even_par(input logic [BYTE_W-1:0] d);
      return ^d;
   endfunction
endpackage

// File: rtl/bsx_sync.sv
module bsx_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bsx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) q[0] <= RST_VAL;
            else        q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= RST_VAL;
            else        q[i] <= q[i-1];
         end
      end
   end

   assign sync_o = q[STAGES-1];
endmodule

// File: rtl/bsx_rx.sv
module bsx_rx
   import bsx_pkg::*;
#(
   parameter int unsigned STOP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              din,
   input  logic              block_start,
   output logic              idle_o,
   output logic [BYTE_W-1:0] data_o,
   output logic              valid_o,
   output logic              par_err_o,
   output logic              frm_err_o
);
   localparam int unsigned LAST  = BYTE_W + STOP_BITS;
   localparam int unsigned CNT_W = $clog2(LAST + 1);
   localparam logic [CNT_W-1:0] PAR_IDX  = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LAST);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              par_bit;
   logic              frm_acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         sh        <= '0;
         par_bit   <= 1'b0;
         frm_acc   <= 1'b0;
         data_o    <= '0;
         valid_o   <= 1'b0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (tick) begin
            case (state)
               RX_IDLE: begin
                  if (!din && !block_start) begin
                     state   <= RX_BUSY;
                     cnt     <= '0;
                     frm_acc <= 1'b0;
                  end
               end
               default: begin
                  cnt <= cnt + 1'b1;
                  if (cnt < PAR_IDX) begin
                     sh <= {din, sh[BYTE_W-1:1]};
                  end else if (cnt == PAR_IDX) begin
                     par_bit <= din;
                  end else if (cnt == LAST_IDX) begin
                     data_o    <= sh;
                     par_err_o <= par_bit ^ even_par(sh);
                     frm_err_o <= frm_acc | ~din;
                     valid_o   <= 1'b1;
                     state     <= RX_IDLE;
                  end else begin
                     frm_acc <= frm_acc | ~din;
                  end
               end
            endcase
         end
      end
   end

   assign idle_o = (state == RX_IDLE);

   // R2: byte strobe lasts one cycle
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   // R2: a strobe always follows a sampled link edge
   a_r2_strobe_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(tick));
   // R8: no new frame starts while the line belongs to the transmitter
   a_r8_no_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && block_start) |=> idle_o);
endmodule

// File: rtl/bsx_tx.sv
module bsx_tx
   import bsx_pkg::*;
#(
   parameter int unsigned STOP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_idle,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              busy_o,
   output logic              dout_o,
   output logic              oe_o
);
   localparam int unsigned FRAME_BITS = BYTE_W + 2 + STOP_BITS;
   localparam int unsigned CNT_W      = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

   logic [FRAME_BITS-1:0] frame_w;
   logic [FRAME_BITS-1:0] sr;
   logic [CNT_W-1:0]      cnt;
   tx_state_e             state;

   assign frame_w[0]        = 1'b0;
   assign frame_w[BYTE_W:1] = data_i;
   assign frame_w[BYTE_W+1] = even_par(data_i);
   for (genvar s = 0; s < STOP_BITS; s++) begin : g_stop
      assign frame_w[BYTE_W+2+s] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= TX_IDLE;
         sr     <= '1;
         cnt    <= '0;
         dout_o <= 1'b1;
         oe_o   <= 1'b0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (start_i) begin
                  sr    <= frame_w;
                  state <= TX_PEND;
               end
            end
            TX_PEND: begin
               if (tick && rx_idle) begin
                  dout_o <= sr[0];
                  oe_o   <= 1'b1;
                  sr     <= {1'b1, sr[FRAME_BITS-1:1]};
                  cnt    <= '0;
                  state  <= TX_SEND;
               end
            end
            default: begin
               if (tick) begin
                  if (cnt == LAST_IDX) begin
                     dout_o <= 1'b1;
                     oe_o   <= 1'b0;
                     state  <= TX_IDLE;
                  end else begin
                     dout_o <= sr[0];
                     sr     <= {1'b1, sr[FRAME_BITS-1:1]};
                     cnt    <= cnt + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign busy_o = (state != TX_IDLE);

   // R5: line outputs move only right after a link edge
   a_r5_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(dout_o) && $stable(oe_o)));
   // R6: released line rests high
   a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_o |-> dout_o);
   // R5: every driven period opens with a low start bit
   a_r5_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_o) |-> !dout_o);
   // R7: driving the line implies busy
   a_r7_oe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      oe_o |-> busy_o);
endmodule

// File: rtl/bitclk_serial_xcvr.sv
module bitclk_serial_xcvr
   import bsx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned TX_STOP_BITS = 2,
   parameter int unsigned RX_STOP_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lnk_clk,
   input  logic              lnk_din,
   output logic              lnk_dout,
   output logic              lnk_oe,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_par_err,
   output logic              rx_frm_err,
   input  logic [BYTE_W-1:0] tx_data,
   input  logic              tx_start,
   output logic              tx_busy
);
   if (TX_STOP_BITS < 1 || TX_STOP_BITS > 2) begin : g_bad_tx_stop
      $error("bitclk_serial_xcvr: TX_STOP_BITS must be 1 or 2");
   end
   if (RX_STOP_BITS < 1 || RX_STOP_BITS > 2) begin : g_bad_rx_stop
      $error("bitclk_serial_xcvr: RX_STOP_BITS must be 1 or 2");
   end

   logic clk_s, clk_prev, din_s, tick, rx_idle;

   bsx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_clk_sync (
      .clk(clk), .rst_n(rst_n), .async_i(lnk_clk), .sync_o(clk_s));
   bsx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_din_sync (
      .clk(clk), .rst_n(rst_n), .async_i(lnk_din), .sync_o(din_s));

   always_ff @(posedge clk) begin
      if (!rst_n) clk_prev <= 1'b1;
      else        clk_prev <= clk_s;
   end
   assign tick = clk_s & ~clk_prev;

   bsx_rx #(.STOP_BITS(RX_STOP_BITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .din(din_s),
      .block_start(tx_busy), .idle_o(rx_idle), .data_o(rx_data),
      .valid_o(rx_valid), .par_err_o(rx_par_err), .frm_err_o(rx_frm_err));

   bsx_tx #(.STOP_BITS(TX_STOP_BITS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_idle(rx_idle),
      .start_i(tx_start), .data_i(tx_data), .busy_o(tx_busy),
      .dout_o(lnk_dout), .oe_o(lnk_oe));

   // R8: a received byte is never strobed while the device drives the line
   a_r8_no_rx_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_oe |-> !rx_valid);
   // R1: first cycle after reset is quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!lnk_oe && lnk_dout && !rx_valid && !tx_busy));
endmodule

// File: tb/bitclk_serial_xcvr_test.sv
module bitclk_serial_xcvr_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lnk_clk = 1'b1;
   logic       host_din = 1'b1;
   logic       lnk_din, lnk_dout, lnk_oe;
   logic [7:0] rx_data;
   logic       rx_valid, rx_par_err, rx_frm_err;
   logic [7:0] tx_data = 8'h00;
   logic       tx_start = 1'b0;
   logic       tx_busy;

   int checks = 0;
   int fails = 0;
   int half = 5;
   int rx_count = 0;
   int tx_frames = 0;
   bit done = 1'b0;

   logic [9:0] rxq[$];
   logic [7:0] txq[$];

   always #10 clk = ~clk;

   assign lnk_din = lnk_oe ? lnk_dout : host_din;

   bitclk_serial_xcvr uut (
      .clk(clk), .rst_n(rst_n), .lnk_clk(lnk_clk), .lnk_din(lnk_din),
      .lnk_dout(lnk_dout), .lnk_oe(lnk_oe), .rx_data(rx_data),
      .rx_valid(rx_valid), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
      .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy));

   initial begin
      forever begin
         repeat (half) @(negedge clk);
         lnk_clk = ~lnk_clk;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // host drives one frame, changing data on falling link edges
   task automatic host_send(input logic [7:0] b, input bit bad_par,
                            input bit bad_s1, input bit bad_s2);
      logic [11:0] f;
      f = {~bad_s2, ~bad_s1, (^b) ^ bad_par, b, 1'b0};
      rxq.push_back({b, bad_par, bad_s1 | bad_s2});
      for (int i = 0; i < 12; i++) begin
         @(negedge lnk_clk);
         host_din = f[i];
      end
      @(negedge lnk_clk);
      host_din = 1'b1;
   endtask

   task automatic tx_req(input logic [7:0] b);
      @(negedge clk);
      tx_data  = b;
      tx_start = 1'b1;
      if (!tx_busy) txq.push_back(b);
      @(negedge clk);
      tx_start = 1'b0;
   endtask

   task automatic tx_wait();
      wait (!tx_busy);
      repeat (3) @(posedge lnk_clk);
   endtask

   // receive scoreboard
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         logic [9:0] e;
         rx_count++;
         if (rxq.size() == 0) begin
            chk(1'b0, "R8/R10 unexpected received byte", rx_data, 0);
         end else begin
            e = rxq.pop_front();
            chk(rx_data == e[9:2], "R2 received data", rx_data, e[9:2]);
            chk(rx_par_err == e[1], "R3 parity flag", rx_par_err, e[1]);
            chk(rx_frm_err == e[0], "R4 framing flag", rx_frm_err, e[0]);
         end
      end
   end

   // transmit scoreboard: host samples on rising link edges
   initial begin
      forever begin
         @(posedge lnk_clk);
         if (rst_n && lnk_oe && !lnk_dout) begin
            logic [10:0] got;
            logic [7:0]  e;
            bit          oe_ok;
            oe_ok = 1'b1;
            for (int i = 0; i < 11; i++) begin
               @(posedge lnk_clk);
               got[i] = lnk_dout;
               if (!lnk_oe) oe_ok = 1'b0;
            end
            @(posedge lnk_clk);
            tx_frames++;
            chk(oe_ok, "R6 enable held through frame", oe_ok, 1);
            chk(!lnk_oe, "R6 enable released after last stop", lnk_oe, 0);
            if (txq.size() == 0) begin
               chk(1'b0, "R7 unexpected transmitted frame", got, 0);
            end else begin
               e = txq.pop_front();
               chk(got[7:0] == e, "R5 transmitted data", got[7:0], e);
               chk(got[8] == ^e, "R5 transmitted parity", got[8], ^e);
               chk(got[10:9] == 2'b11, "R5 stop bits", got[10:9], 3);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog expired", 0, 1);
         summary();
      end
   end

   initial begin
      int n0;
      int f0;
      bit bad;
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!lnk_oe, "R1 reset enable", lnk_oe, 0);
      chk(lnk_dout, "R1 reset data out", lnk_dout, 1);
      chk(!rx_valid, "R1 reset strobe", rx_valid, 0);
      chk(!tx_busy, "R1 reset busy", tx_busy, 0);

      // R10: idle line high produces nothing
      repeat (20) @(posedge lnk_clk);
      chk(rx_count == 0, "R10 idle line gives no byte", rx_count, 0);

      // R2 R3: clean frames of several patterns
      host_send(8'hA5, 0, 0, 0);
      host_send(8'h00, 0, 0, 0);
      host_send(8'hFF, 0, 0, 0);
      host_send(8'h3C, 0, 0, 0);
      // R3: parity mismatch
      host_send(8'h5A, 1, 0, 0);
      // R4: each stop position low
      host_send(8'h81, 0, 1, 0);
      host_send(8'h7E, 0, 0, 1);
      repeat (4) @(posedge lnk_clk);
      chk(rx_count == 7, "R2 byte count", rx_count, 7);

      // R5 R6: single reply
      tx_req(8'hC3);
      tx_wait();

      // R7: request while busy is dropped
      f0 = tx_frames;
      tx_req(8'h81);
      @(negedge clk);
      chk(tx_busy, "R7 busy after accepted request", tx_busy, 1);
      repeat (2) @(posedge lnk_clk);
      tx_req(8'h7E);
      tx_wait();
      repeat (14) @(posedge lnk_clk);
      chk(tx_frames == f0 + 1, "R7 only one frame sent", tx_frames, f0 + 1);
      chk(txq.size() == 0, "R7 expected frames all seen", txq.size(), 0);

      // R8: reply requested during a host frame waits for it
      bad = 1'b0;
      n0 = rx_count;
      fork
         host_send(8'h0F, 0, 0, 0);
         begin
            repeat (4) @(negedge lnk_clk);
            tx_req(8'h55);
            while (rx_count == n0) begin
               @(negedge clk);
               if (lnk_oe) bad = 1'b1;
            end
         end
      join
      chk(!bad, "R8 line not driven during host frame", bad, 0);
      tx_wait();
      chk(rx_count == n0 + 1, "R8 host frame delivered once", rx_count, n0 + 1);

      // R9: slow link clock
      half = 20;
      repeat (3) @(posedge lnk_clk);
      host_send(8'h96, 0, 0, 0);
      host_send(8'h2D, 1, 0, 0);
      repeat (3) @(posedge lnk_clk);
      tx_req(8'h69);
      tx_wait();
      // R9: fast link clock
      half = 4;
      repeat (3) @(posedge lnk_clk);
      host_send(8'hE1, 0, 0, 0);
      repeat (3) @(posedge lnk_clk);
      tx_req(8'h1E);
      tx_wait();
      repeat (4) @(posedge lnk_clk);
      chk(rxq.size() == 0, "R9 all host frames received", rxq.size(), 0);
      chk(txq.size() == 0, "R9 all replies seen", txq.size(), 0);

      done = 1'b1;
      summary();
   end
endmodule